// File: doc/BRIEF.md
# Multiplexed video bus serializer

This block takes one parallel pixel per pixel period and spreads it over four clocks of a narrow 7-bit bus. The bus clock runs at four times the pixel rate. Each pixel carries red, green and blue values of 7 bits each, four active-low control flags (composite sync, horizontal sync, clamp gate and vertical sync) and a blanking indication. For an active pixel the bus carries one control word and then the three colour words. An active-low strobe is low during the control word and marks the start of each pixel.

During blanking the block stays in the control phase. It sends a fresh control word on every bus clock, so the strobe stays low for as many clocks as the blanking lasts. The upstream timing generator delivers pixels through a valid/ready handshake. The block takes a pixel only at the point where the sequence is about to return to the control phase. The accepted pixel is held in a register, so the colour words do not depend on the inputs during phases 1 to 3.

The state machine has four states. CTRL sends the control word. RED, GREEN and BLUE send the three colour words. It has these transitions:
- CTRL to RED, when the held pixel is active.
- CTRL to CTRL, when the held pixel is blanking. This is the blanking repeat.
- RED to GREEN.
- GREEN to BLUE.
- BLUE to CTRL. This is the wrap.

Top module: `vbus_serializer`

## Requirements
- R1: A synchronous active-high reset puts the block in CTRL with all four flags high (inactive). The bus then shows 7'h0F with the strobe low and ready high. While reset is held, this state repeats on every clock.
- R2: An active pixel accepted at a clock edge produces this sequence on the next four clocks: the control word, then red, then green, then blue.
- R3: In the control word, bit 0 is composite sync, bit 1 is horizontal sync, bit 2 is the clamp gate and bit 3 is vertical sync, each copied as given (active low). Bits 4 to 6 are zero.
- R4: The strobe is low in the control phase and high in the three colour phases. After three colour words the next word is always a control word.
- R5: Ready is high in the BLUE phase and in a CTRL phase that holds a blanking pixel. Ready is low in every other state. A pixel is accepted on a clock edge where both valid and ready are high.
- R6: Input changes while ready is low have no effect: the colour words and the next control word come from the pixel that was accepted.
- R7: A blanking pixel produces exactly one control word. The block stays in CTRL with ready high, so consecutive blanking pixels give one control word per clock with the strobe held low.
- R8: If valid is low at an edge where ready is high, the block keeps the last accepted flags and enters blanking. It repeats that control word every clock until a pixel arrives.
- R9: The first active pixel after blanking produces a full four-word sequence that starts with its control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, four times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Upstream pixel is present |
| pix_ready | output | 1 | Pixel is taken at this edge if valid is high |
| pix_blank | input | 1 | Pixel belongs to blanking (control word only) |
| pix_csync_n | input | 1 | Composite sync, active low |
| pix_hsync_n | input | 1 | Horizontal sync, active low |
| pix_clamp_n | input | 1 | Clamp / colour-burst gate, active low |
| pix_vsync_n | input | 1 | Vertical sync, active low |
| pix_red | input | 7 | Red component |
| pix_green | input | 7 | Green component |
| pix_blue | input | 7 | Blue component |
| bus_data | output | 7 | Multiplexed bus word |
| bus_strobe_n | output | 1 | Active-low strobe, low during control words |

## Verification
The hardest case to reach from the ports is a pixel that is accepted in the same cycle the block leaves a blanking repeat. The next state in that cycle depends on the old held blank bit, while the new flags are loaded at the same edge. The stimulus streams pixels back to back from a table. Each pixel is driven in the very cycle that ready rises, and blanking entries are placed directly before active ones, so both the repeat-to-active and the blue-to-blank wraps occur without idle gaps. While ready is low, inverted garbage is driven on the inputs, and an underflow is forced by withholding valid at a wrap.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
    parameter int COLOR_W = 7;
    parameter int BUS_W   = 7;
    localparam int FLAG_N = 4;
    localparam int PAD_W  = BUS_W - FLAG_N;

    typedef enum logic [1:0] {
        PH_CTRL  = 2'd0,
        PH_RED   = 2'd1,
        PH_GREEN = 2'd2,
        PH_BLUE  = 2'd3
    } phase_t;

    typedef struct packed {
        logic               blank;
        logic               vsync_n;
        logic               clamp_n;
        logic               hsync_n;
        logic               csync_n;
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } pixel_t;
endpackage

// File: rtl/vbus_hold.sv
module vbus_hold
    import vbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   valid,
    input  pixel_t din,
    output pixel_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.blank   <= 1'b1;
            q.vsync_n <= 1'b1;
            q.clamp_n <= 1'b1;
            q.hsync_n <= 1'b1;
            q.csync_n <= 1'b1;
            q.red     <= '0;
            q.green   <= '0;
            q.blue    <= '0;
        end else if (take) begin
            if (valid) begin
                q <= din;
            end else begin
                q.blank <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vbus_phase_fsm.sv
module vbus_phase_fsm
    import vbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   held_blank,
    output phase_t phase,
    output logic   wrap
);
    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_CTRL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        unique case (state_q)
            PH_CTRL: begin
                if (held_blank) begin
                    state_d = PH_CTRL;
                    wrap    = 1'b1;
                end else begin
                    state_d = PH_RED;
                end
            end
            PH_RED:   state_d = PH_GREEN;
            PH_GREEN: state_d = PH_BLUE;
            PH_BLUE: begin
                state_d = PH_CTRL;
                wrap    = 1'b1;
            end
            default:  state_d = PH_CTRL;
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/vbus_word_mux.sv
module vbus_word_mux
    import vbus_pkg::*;
(
    input  phase_t           phase,
    input  pixel_t           held,
    output logic [BUS_W-1:0] data,
    output logic             strobe_n
);
    always_comb begin
        data     = '0;
        strobe_n = 1'b1;
        unique case (phase)
            PH_CTRL: begin
                data     = {{PAD_W{1'b0}}, held.vsync_n, held.clamp_n,
                            held.hsync_n, held.csync_n};
                strobe_n = 1'b0;
            end
            PH_RED:   data = BUS_W'(held.red);
            PH_GREEN: data = BUS_W'(held.green);
            PH_BLUE:  data = BUS_W'(held.blue);
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/vbus_serializer.sv
module vbus_serializer
    import vbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic               pix_blank,
    input  logic               pix_csync_n,
    input  logic               pix_hsync_n,
    input  logic               pix_clamp_n,
    input  logic               pix_vsync_n,
    input  logic [COLOR_W-1:0] pix_red,
    input  logic [COLOR_W-1:0] pix_green,
    input  logic [COLOR_W-1:0] pix_blue,
    output logic [BUS_W-1:0]   bus_data,
    output logic               bus_strobe_n
);
    pixel_t in_pix;
    pixel_t held;
    phase_t phase;
    logic   wrap;

    assign in_pix = '{blank: pix_blank, vsync_n: pix_vsync_n,
                      clamp_n: pix_clamp_n, hsync_n: pix_hsync_n,
                      csync_n: pix_csync_n, red: pix_red,
                      green: pix_green, blue: pix_blue};

    vbus_phase_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .held_blank (held.blank),
        .phase      (phase),
        .wrap       (wrap)
    );

    vbus_hold i_hold (
        .clk   (clk),
        .rst   (rst),
        .take  (wrap),
        .valid (pix_valid),
        .din   (in_pix),
        .q     (held)
    );

    vbus_word_mux i_mux (
        .phase    (phase),
        .held     (held),
        .data     (bus_data),
        .strobe_n (bus_strobe_n)
    );

    assign pix_ready = wrap;
endmodule

// File: rtl/vbus_checker.sv
module vbus_checker
    import vbus_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pix_valid,
    input logic               pix_ready,
    input logic               pix_blank,
    input logic [COLOR_W-1:0] pix_red,
    input logic [BUS_W-1:0]   bus_data,
    input logic               bus_strobe_n
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!bus_strobe_n && bus_data == BUS_W'(7'h0F) && pix_ready));

    assert_red_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && pix_valid && !pix_blank) |=> ##1
        (bus_strobe_n && bus_data == BUS_W'($past(pix_red, 2))));

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe_n |-> bus_data[BUS_W-1:FLAG_N] == '0);

    assert_ctrl_after_colors_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe_n && $past(bus_strobe_n) && $past(bus_strobe_n, 2)) |=> !bus_strobe_n);

    assert_wrap_to_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
        pix_ready |=> !bus_strobe_n);

    assert_ready_only_ctrl_or_color_R5: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && pix_valid && !pix_blank) |=> (!bus_strobe_n && !pix_ready));

    assert_blank_repeat_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && pix_valid && pix_blank) |=> (!bus_strobe_n && pix_ready));

    assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && !pix_valid) |=> (!bus_strobe_n && pix_ready));
endmodule

bind vbus_serializer vbus_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix_valid),
    .pix_ready    (pix_ready),
    .pix_blank    (pix_blank),
    .pix_red      (pix_red),
    .bus_data     (bus_data),
    .bus_strobe_n (bus_strobe_n)
);

// File: tb/test_vbus_serializer.sv
module test_vbus_serializer;
    localparam int CLK_NS = 20;
    localparam int NVEC   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic       pix_blank = 1'b0;
    logic       pix_csync_n = 1'b1;
    logic       pix_hsync_n = 1'b1;
    logic       pix_clamp_n = 1'b1;
    logic       pix_vsync_n = 1'b1;
    logic [6:0] pix_red = '0;
    logic [6:0] pix_green = '0;
    logic [6:0] pix_blue = '0;
    logic [6:0] bus_data;
    logic       bus_strobe_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // entry: blank, flags {vsync,clamp,hsync,csync}, red, green, blue
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 4'hE, 7'h55, 7'h2A, 7'h7F},
        {1'b0, 4'hD, 7'h01, 7'h40, 7'h00},
        {1'b1, 4'hB, 7'h33, 7'h44, 7'h11},
        {1'b1, 4'h7, 7'h12, 7'h34, 7'h56},
        {1'b1, 4'h0, 7'h7F, 7'h7F, 7'h7F},
        {1'b0, 4'hF, 7'h6B, 7'h19, 7'h3C},
        {1'b1, 4'h5, 7'h00, 7'h00, 7'h00},
        {1'b0, 4'hA, 7'h7E, 7'h03, 7'h5A}
    };

    always #(CLK_NS/2) clk = ~clk;

    vbus_serializer i_vbus_serializer (
        .clk          (clk),
        .rst          (rst),
        .pix_valid    (pix_valid),
        .pix_ready    (pix_ready),
        .pix_blank    (pix_blank),
        .pix_csync_n  (pix_csync_n),
        .pix_hsync_n  (pix_hsync_n),
        .pix_clamp_n  (pix_clamp_n),
        .pix_vsync_n  (pix_vsync_n),
        .pix_red      (pix_red),
        .pix_green    (pix_green),
        .pix_blue     (pix_blue),
        .bus_data     (bus_data),
        .bus_strobe_n (bus_strobe_n)
    );

    // compares {ready, strobe_n, data}
    task automatic chk(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {pix_ready, bus_strobe_n, bus_data};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ready/strobe/data actual=%b/%b/%h expected=%b/%b/%h",
                     req, act[8], act[7], act[6:0], exp[8], exp[7], exp[6:0]);
        end
    endtask

    task automatic drive(input logic [25:0] v, input logic vld);
        pix_valid   = vld;
        pix_blank   = v[25];
        pix_vsync_n = v[24];
        pix_clamp_n = v[23];
        pix_hsync_n = v[22];
        pix_csync_n = v[21];
        pix_red     = v[20:14];
        pix_green   = v[13:7];
        pix_blue    = v[6:0];
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [25:0] last;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {1'b1, 1'b1 ^ 1'b1, 7'h0F});
        rst = 1'b0;
        step();
        chk("R8 idle repeat after reset", {1'b1, 1'b0, 7'h0F});

        last = '0;
        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(v, 1'b1);
            step();
            chk(v[25] ? "R7 blank control word" : "R3 R9 control word",
                {v[25], 1'b0, 3'b000, v[24:21]});
            if (!v[25]) begin
                drive(~v, 1'b1);
                step();
                chk("R2 R4 red phase", {1'b0, 1'b1, v[20:14]});
                step();
                chk("R6 green phase held", {1'b0, 1'b1, v[13:7]});
                step();
                chk("R5 blue phase ready", {1'b1, 1'b1, v[6:0]});
            end
            last = v;
        end

        drive(~last, 1'b0);
        step();
        chk("R8 underflow keeps flags", {1'b1, 1'b0, 3'b000, last[24:21]});
        step();
        chk("R8 underflow repeats", {1'b1, 1'b0, 3'b000, last[24:21]});

        drive(VEC[0], 1'b1);
        step();
        chk("R9 leave blanking control", {1'b0, 1'b0, 3'b000, VEC[0][24:21]});
        pix_valid = 1'b0;
        step();
        chk("R2 red after blanking", {1'b0, 1'b1, VEC[0][20:14]});
        rst = 1'b1;
        step();
        chk("R1 reset mid pixel", {1'b1, 1'b0, 7'h0F});
        step();
        chk("R1 reset held", {1'b1, 1'b0, 7'h0F});
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule